// File: doc/BRIEF.md
# Serial Flash SPI Target Front End

This block is the serial link layer of a flash-style SPI target. Every pin is oversampled by a faster system clock: SCK, chip select, hold and both data pins pass through two-flop synchronisers. SCK edges are then found from the synchronised samples. The block turns the serial bit stream into bytes for a command decoder and turns bytes from that decoder back into a serial stream. Each direction can move one bit per SCK edge or two bits per SCK edge. In two-bit mode the unused data pin changes direction.

Chip select frames every transaction. Its falling edge restarts the bit counters, and its rising edge discards any byte that is not complete. A hold input can freeze the link in the middle of a frame. Hold does not reach the busy flag of a program or erase operation that is running, which passes through the block untouched. The decoder selects one-bit or two-bit transfer through two mode inputs. It receives each byte on a one-cycle valid strobe. It supplies the next outgoing byte when the block pulses a load strobe.

Top module: `spi_flash_front`

## Requirements
- R1: Input bits are sampled on rising SCK edges, whether SCK idles low (mode 0) or high (mode 3) when chip select falls. A falling SCK edge that no rising edge in the same frame has preceded shifts nothing.
- R2: While `cs_n_i` is high, SCK and data activity produce no received byte. `frame_start_o` pulses once per falling edge of chip select, and `frame_end_o` pulses once per rising edge.
- R3: In one-bit input mode (`dual_in_i`=0), eight rising edges capture `io0_i` MSB first. The byte appears on `rx_data_o` with `rx_valid_o` high for exactly one clock.
- R4: In two-bit input mode (`dual_in_i`=1), each rising edge captures two bits as {`io1_i`, `io0_i`}, with `io1_i` as the higher bit. Four edges make a byte, and `io1_oe_o` is low for the whole frame.
- R5: In one-bit output mode, `io1_o` shows the MSB of `tx_data_i` as latched when chip select falls. Each later falling SCK edge advances one bit. When a byte is used up, the next byte is latched from `tx_data_i`. `tx_load_o` pulses once at each latch.
- R6: In two-bit output mode (`dual_out_i`=1), `io0_oe_o` is high and each falling edge advances two bits. `io0_o` carries the higher bit of the pair and `io1_o` the lower one.
- R7: Both output enables are low while chip select is high.
- R8: Hold starts only when `hold_n_i` is low while chip select is low and SCK is low. A hold request made while SCK is high or chip select is high leaves `hold_active_o` low.
- R9: While `hold_active_o` is high, both output enables are low, and SCK edges and data are ignored. After hold is released, a byte that was interrupted completes with its value unchanged.
- R10: `busy_o` follows `busy_i` one clock later, whether hold is active or not.
- R11: A byte that is not complete when chip select rises is discarded. The next frame starts counting from bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Chip select, active low |
| hold_n_i | input | 1 | Hold request, active low |
| io0_i | input | 1 | Serial input pin, primary data in |
| io0_o | output | 1 | Serial input pin value when it drives out in two-bit read |
| io0_oe_o | output | 1 | Drive enable for the serial input pin |
| io1_i | input | 1 | Serial output pin, sampled as the higher bit in two-bit write |
| io1_o | output | 1 | Serial output data |
| io1_oe_o | output | 1 | Drive enable for the serial output pin |
| dual_in_i | input | 1 | Select two bits per rising edge for input |
| dual_out_i | input | 1 | Select two bits per falling edge for output |
| rx_data_o | output | 8 | Byte assembled from the input pins |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| tx_data_i | input | 8 | Next byte to send |
| tx_load_o | output | 1 | Pulses when `tx_data_i` has been latched |
| frame_start_o | output | 1 | Pulse on a falling edge of chip select |
| frame_end_o | output | 1 | Pulse on a rising edge of chip select |
| hold_active_o | output | 1 | Link is paused by hold |
| busy_i | input | 1 | Busy flag of the internal self-timed operation |
| busy_o | output | 1 | Registered copy of `busy_i` |

## Verification
Received bytes are tried with alternating, nibble-swapped and edge-heavy patterns such as A5, 3C, 5A and C9. These show whether bit order is reversed or a lane is swapped in two-bit mode. Output bytes 96/4B and D2 separate the first-bit latch at chip select from the reload after eight falling edges, and show which pin carries the higher bit in two-bit read. A frame cut after five ones, followed by 81, shows whether the counter clears on chip select. A byte split by a hold with toggling SCK and flipped data shows whether edges are ignored during hold and whether the interrupted byte resumes intact.

// File: rtl/spi_front_pkg.sv
// Shared types for the serial flash front end.
// Assumes nothing beyond IEEE 1800-2017 packages.
package spi_front_pkg;

    // Link events found on one system clock cycle.
    typedef struct packed {
        logic frame_start;
        logic frame_end;
        logic rise;
        logic fall;
    } link_ev_t;

    // Bits moved per SCK edge.
    typedef enum logic {
        LANE_X1 = 1'b0,
        LANE_X2 = 1'b1
    } lane_t;

endpackage

// File: rtl/sfe_sync.sv
// Multi-stage flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is sampled independently. RST_VAL sets each bit's idle level.
module sfe_sync #(
    parameter int         W       = 5,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= d_i;
                end
            end else begin : g_next
                // Later stages settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sfe_link.sv
// Link control: chip-select framing, SCK edge detection and the hold state.
// Assumes synchronised inputs. Edges are passed on only while selected and not
// held. A falling edge counts only after a rising edge in the same frame.
module sfe_link
    import spi_front_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sck_s,
    input  logic     cs_n_s,
    input  logic     hold_n_s,
    output link_ev_t ev_o,
    output logic     cs_act_o,
    output logic     hold_act_o
);

    logic sck_q;
    logic cs_n_q;
    logic hold_q;
    logic hold_d;
    logic seen_rise_q;
    logic cs_act;

    assign cs_act = !cs_n_s;

    // Hold may start only while selected with SCK low. Deselect clears it.
    always_comb begin
        if (!cs_act)      hold_d = 1'b0;
        else if (hold_q)  hold_d = !hold_n_s;
        else              hold_d = !hold_n_s && !sck_s;
    end

    // Previous-sample registers used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_n_q <= 1'b1;
            hold_q <= 1'b0;
        end else begin
            sck_q  <= sck_s;
            cs_n_q <= cs_n_s;
            hold_q <= hold_d;
        end
    end

    // Event decode from current and previous samples.
    always_comb begin
        ev_o.frame_start = cs_n_q && !cs_n_s;
        ev_o.frame_end   = !cs_n_q && cs_n_s;
        ev_o.rise        = sck_s && !sck_q && cs_act && !hold_q;
        ev_o.fall        = !sck_s && sck_q && cs_act && !hold_q && seen_rise_q;
    end

    // Remembers whether this frame has seen a rising edge (for mode 3 start).
    always_ff @(posedge clk) begin
        if (!rst_n)                      seen_rise_q <= 1'b0;
        else if (!cs_act || ev_o.frame_start) seen_rise_q <= 1'b0;
        else if (ev_o.rise)              seen_rise_q <= 1'b1;
    end

    assign cs_act_o   = cs_act;
    assign hold_act_o = hold_q;

endmodule

// File: rtl/sfe_rx.sv
// Receive shifter: assembles bytes MSB first, one or two bits per rising edge.
// Assumes BYTE_W is even, so the two-bit mode fills a byte exactly.
// Chip-select edges discard any bits already collected.
module sfe_rx
    import spi_front_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              frame_end_i,
    input  logic              rise_i,
    input  lane_t             lane_i,
    input  logic              io0_s,
    input  logic              io1_s,
    output logic [BYTE_W-1:0] data_o,
    output logic              valid_o
);

    localparam int CNT_W = $clog2(BYTE_W) + 2;

    logic [BYTE_W-1:0] sr_q, sr_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // Next shift value and bit count for the chosen lane width.
    always_comb begin
        if (lane_i == LANE_X2) begin
            sr_d  = {sr_q[BYTE_W-3:0], io1_s, io0_s};
            cnt_d = cnt_q + CNT_W'(2);
        end else begin
            sr_d  = {sr_q[BYTE_W-2:0], io0_s};
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    // Shift, count and emit a byte when full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= '0;
            cnt_q   <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (frame_start_i || frame_end_i) begin
                sr_q  <= '0;
                cnt_q <= '0;
            end else if (rise_i) begin
                if (cnt_d >= CNT_W'(BYTE_W)) begin
                    data_o  <= sr_d;
                    valid_o <= 1'b1;
                    cnt_q   <= '0;
                    sr_q    <= '0;
                end else begin
                    sr_q  <= sr_d;
                    cnt_q <= cnt_d;
                end
            end
        end
    end

endmodule

// File: rtl/sfe_tx.sv
// Transmit shifter: sends bytes MSB first, one or two bits per falling edge.
// Assumes the decoder holds tx_data_i valid at each load. A byte is latched at
// the start of the frame and again whenever the current byte runs out.
module sfe_tx
    import spi_front_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              fall_i,
    input  lane_t             lane_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              load_o,
    output logic              io0_o,
    output logic              io1_o
);

    localparam int CNT_W = $clog2(BYTE_W) + 2;

    logic [BYTE_W-1:0] sr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [CNT_W-1:0]  step;

    assign step = (lane_i == LANE_X2) ? CNT_W'(2) : CNT_W'(1);

    // Load at frame start or when empty; shift on each counted falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            rem_q  <= '0;
            load_o <= 1'b0;
        end else begin
            load_o <= 1'b0;
            if (frame_start_i || (fall_i && rem_q <= step)) begin
                sr_q   <= data_i;
                rem_q  <= CNT_W'(BYTE_W);
                load_o <= 1'b1;
            end else if (fall_i) begin
                sr_q  <= (lane_i == LANE_X2) ? (sr_q << 2) : (sr_q << 1);
                rem_q <= rem_q - step;
            end
        end
    end

    // Pin mapping: in two-bit mode the turned-around pin carries the higher bit.
    always_comb begin
        if (lane_i == LANE_X2) begin
            io0_o = sr_q[BYTE_W-1];
            io1_o = sr_q[BYTE_W-2];
        end else begin
            io0_o = 1'b0;
            io1_o = sr_q[BYTE_W-1];
        end
    end

endmodule

// File: rtl/spi_flash_front.sv
// Top of the serial flash front end: synchronisers, link control, shifters.
// Assumes clk is at least four times faster than SCK and that the mode inputs
// change only between bytes.
module spi_flash_front
    import spi_front_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              hold_n_i,
    input  logic              io0_i,
    output logic              io0_o,
    output logic              io0_oe_o,
    input  logic              io1_i,
    output logic              io1_o,
    output logic              io1_oe_o,
    input  logic              dual_in_i,
    input  logic              dual_out_i,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              tx_load_o,
    output logic              frame_start_o,
    output logic              frame_end_o,
    output logic              hold_active_o,
    input  logic              busy_i,
    output logic              busy_o
);

    localparam int NSYNC = 5;
    localparam logic [NSYNC-1:0] SYNC_RST = 5'b01100;

    logic [NSYNC-1:0] raw, synced;
    logic sck_lvl, cs_n_lvl, hold_n_lvl, io1_lvl, io0_lvl;
    logic cs_act;
    link_ev_t ev;
    lane_t lane_in, lane_out;

    assign raw = {sck_i, cs_n_i, hold_n_i, io1_i, io0_i};
    assign {sck_lvl, cs_n_lvl, hold_n_lvl, io1_lvl, io0_lvl} = synced;

    assign lane_in  = dual_in_i  ? LANE_X2 : LANE_X1;
    assign lane_out = dual_out_i ? LANE_X2 : LANE_X1;

    sfe_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (synced)
    );

    sfe_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (sck_lvl),
        .cs_n_s     (cs_n_lvl),
        .hold_n_s   (hold_n_lvl),
        .ev_o       (ev),
        .cs_act_o   (cs_act),
        .hold_act_o (hold_active_o)
    );

    sfe_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (ev.frame_start),
        .frame_end_i   (ev.frame_end),
        .rise_i        (ev.rise),
        .lane_i        (lane_in),
        .io0_s         (io0_lvl),
        .io1_s         (io1_lvl),
        .data_o        (rx_data_o),
        .valid_o       (rx_valid_o)
    );

    sfe_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (ev.frame_start),
        .fall_i        (ev.fall),
        .lane_i        (lane_out),
        .data_i        (tx_data_i),
        .load_o        (tx_load_o),
        .io0_o         (io0_o),
        .io1_o         (io1_o)
    );

    // Pin direction: drive only when selected, not held, and the lane allows it.
    always_comb begin
        io1_oe_o = cs_act && !hold_active_o && !dual_in_i;
        io0_oe_o = cs_act && !hold_active_o && dual_out_i && !dual_in_i;
    end

    assign frame_start_o = ev.frame_start;
    assign frame_end_o   = ev.frame_end;

    // Busy pass-through, independent of the link and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_o <= 1'b0;
        else        busy_o <= busy_i;
    end

endmodule

// File: rtl/spi_flash_front_chk.sv
// Property checker for spi_flash_front, attached by bind.
// Assumes the top-level signals cs_act and sck_lvl are visible by name.
module spi_flash_front_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_act,
    input logic sck_lvl,
    input logic hold_active_o,
    input logic io0_oe_o,
    input logic io1_oe_o,
    input logic rx_valid_o,
    input logic tx_load_o,
    input logic busy_i,
    input logic busy_o
);

    AST_RX_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(cs_act)); // R2

    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R3

    AST_TX_LOAD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> $past(cs_act)); // R5

    AST_HOLD_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active_o) |-> ($past(cs_act) && !$past(sck_lvl))); // R8

    AST_HOLD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active_o |-> (!io0_oe_o && !io1_oe_o)); // R9

    AST_BUSY_THROUGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active_o && busy_i) |=> busy_o); // R10

endmodule

bind spi_flash_front spi_flash_front_chk u_chk (.*);

// File: tb/sim_spi_flash_front.sv
// Directed bench for spi_flash_front: one task per scenario.
module sim_spi_flash_front;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
    logic       si = 1'b0, so_in = 1'b0;
    logic       dual_in = 1'b0, dual_out = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       busy_in = 1'b0;

    logic       io0_o, io0_oe, io1_o, io1_oe;
    logic [7:0] rx_data;
    logic       rx_valid, tx_load, f_start, f_end, hold_act, busy_out;

    int vectors = 0;
    int miscompares = 0;
    int rx_cnt = 0;
    int load_cnt = 0;
    logic [15:0] rx_hist = '0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_flash_front u0 (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
        .io0_i(si), .io0_o(io0_o), .io0_oe_o(io0_oe),
        .io1_i(so_in), .io1_o(io1_o), .io1_oe_o(io1_oe),
        .dual_in_i(dual_in), .dual_out_i(dual_out),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid),
        .tx_data_i(tx_data), .tx_load_o(tx_load),
        .frame_start_o(f_start), .frame_end_o(f_end),
        .hold_active_o(hold_act), .busy_i(busy_in), .busy_o(busy_out)
    );

    // Records strobes away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt++;
            rx_hist = {rx_hist[7:0], rx_data};
        end
        if (tx_load) load_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bitx(input logic [1:0] d, output logic [1:0] got);
        sck = 1'b0; si = d[0]; so_in = d[1];
        wclk(HALF);
        got = {io0_o, io1_o};
        sck = 1'b1;
        wclk(HALF);
    endtask

    task automatic begin_frame(input logic idle);
        sck = idle; wclk(HALF);
        cs_n = 1'b0; wclk(HALF);
    endtask

    task automatic end_frame();
        wclk(HALF); cs_n = 1'b1; wclk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit two);
        logic [1:0] g;
        if (two) for (int i = 3; i >= 0; i--) bitx(b[2*i +: 2], g);
        else     for (int i = 7; i >= 0; i--) bitx({1'b0, b[i]}, g);
    endtask

    task automatic t_reset();
        chk("R7 io0_oe after reset", io0_oe, 0);
        chk("R7 io1_oe after reset", io1_oe, 0);
        chk("R3 rx_valid after reset", rx_valid, 0);
        chk("R9 hold after reset", hold_act, 0);
    endtask

    task automatic t_mode0_single();
        int c0 = rx_cnt;
        begin_frame(1'b0);
        send_byte(8'hA5, 0);
        send_byte(8'h3C, 0);
        end_frame();
        chk("R3 byte count mode0", rx_cnt - c0, 2);
        chk("R1 R3 bytes mode0", rx_hist, 16'hA53C);
    endtask

    task automatic t_mode3();
        int c0 = rx_cnt;
        begin_frame(1'b1);
        send_byte(8'h5A, 0);
        end_frame();
        chk("R1 byte count mode3", rx_cnt - c0, 1);
        chk("R1 byte mode3", rx_hist[7:0], 8'h5A);
    endtask

    task automatic t_dual_in();
        int c0 = rx_cnt;
        dual_in = 1'b1;
        begin_frame(1'b0);
        chk("R4 io1_oe off in dual input", io1_oe, 0);
        send_byte(8'hC9, 1);
        end_frame();
        dual_in = 1'b0;
        chk("R4 byte count dual", rx_cnt - c0, 1);
        chk("R4 byte dual", rx_hist[7:0], 8'hC9);
    endtask

    task automatic t_abandon();
        int c0 = rx_cnt;
        logic [1:0] g;
        begin_frame(1'b0);
        for (int i = 0; i < 5; i++) bitx(2'b01, g);
        end_frame();
        chk("R11 no byte from partial", rx_cnt - c0, 0);
        begin_frame(1'b0);
        send_byte(8'h81, 0);
        end_frame();
        chk("R11 next frame byte count", rx_cnt - c0, 1);
        chk("R11 next frame byte", rx_hist[7:0], 8'h81);
    endtask

    task automatic t_deselect();
        int c0 = rx_cnt;
        int l0 = load_cnt;
        si = 1'b1;
        for (int i = 0; i < 16; i++) begin
            sck = ~sck; wclk(HALF);
        end
        sck = 1'b0; wclk(HALF);
        chk("R2 no byte while deselected", rx_cnt - c0, 0);
        chk("R5 no load while deselected", load_cnt - l0, 0);
        chk("R7 io1_oe deselected", io1_oe, 0);
        chk("R7 io0_oe deselected", io0_oe, 0);
    endtask

    task automatic t_tx_single();
        int l0 = load_cnt;
        logic [1:0] g;
        logic [15:0] got = '0;
        tx_data = 8'h96;
        begin_frame(1'b0);
        chk("R5 io1_oe in frame", io1_oe, 1);
        chk("R6 io0_oe off in single", io0_oe, 0);
        for (int i = 0; i < 16; i++) begin
            bitx(2'b00, g);
            got = {got[14:0], g[0]};
            if (i == 0) tx_data = 8'h4B;
        end
        end_frame();
        chk("R5 first byte out", got[15:8], 8'h96);
        chk("R5 second byte out", got[7:0], 8'h4B);
        chk("R5 load pulses", load_cnt - l0, 2);
    endtask

    task automatic t_tx_dual();
        logic [1:0] g;
        logic [7:0] got = '0;
        dual_out = 1'b1;
        tx_data = 8'hD2;
        begin_frame(1'b0);
        chk("R6 io0_oe in dual output", io0_oe, 1);
        for (int i = 0; i < 4; i++) begin
            bitx(2'b00, g);
            got = {got[5:0], g};
        end
        end_frame();
        dual_out = 1'b0;
        chk("R6 dual output byte", got, 8'hD2);
    endtask

    task automatic t_hold();
        int c0 = rx_cnt;
        logic [7:0] b = 8'hB7;
        logic [1:0] g;
        begin_frame(1'b0);
        for (int i = 7; i >= 4; i--) bitx({1'b0, b[i]}, g);
        sck = 1'b0; wclk(HALF);
        hold_n = 1'b0; busy_in = 1'b1;
        wclk(8);
        chk("R9 hold active", hold_act, 1);
        chk("R9 io1_oe off in hold", io1_oe, 0);
        chk("R10 busy high during hold", busy_out, 1);
        for (int i = 0; i < 6; i++) begin
            sck = ~sck; si = ~si; wclk(HALF);
        end
        sck = 1'b0; busy_in = 1'b0;
        wclk(8);
        chk("R10 busy low during hold", busy_out, 0);
        chk("R9 no byte during hold", rx_cnt - c0, 0);
        hold_n = 1'b1;
        wclk(8);
        chk("R9 hold released", hold_act, 0);
        for (int i = 3; i >= 0; i--) bitx({1'b0, b[i]}, g);
        end_frame();
        chk("R9 byte across hold count", rx_cnt - c0, 1);
        chk("R9 byte across hold", rx_hist[7:0], 8'hB7);
    endtask

    task automatic t_hold_gating();
        begin_frame(1'b0);
        sck = 1'b1; wclk(HALF);
        hold_n = 1'b0; wclk(8);
        chk("R8 no hold with SCK high", hold_act, 0);
        hold_n = 1'b1; wclk(8);
        end_frame();
        hold_n = 1'b0; wclk(8);
        chk("R8 no hold while deselected", hold_act, 0);
        hold_n = 1'b1; wclk(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_mode0_single();
        t_mode3();
        t_dual_in();
        t_abandon();
        t_deselect();
        t_tx_single();
        t_tx_dual();
        t_hold();
        t_hold_gating();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule